// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether an incoming Ethernet frame belongs to a subscribed group address. It takes the six destination-address bytes one per accepted cycle and runs them through a byte-wide CRC-32 engine. From the result it forms an 8-bit hash and uses that hash to pick one bit out of a 256-bit group table. The table is supplied as eight 32-bit words. A set bit means "accept".

A pass-all control accepts every group-addressed frame without looking at the table. Frames whose first address byte marks them as individual (unicast) addresses are never hash-matched and are reported as rejected. The decision appears together with a single-cycle done strobe, one cycle after the sixth address byte is taken. A start marker on any byte begins a new address and throws away any partially hashed one.

Top module: `mcast_hash_filter`

## Requirements
- R1: After synchronous reset, `done_o` and `accept_o` are 0, and they stay 0 until a full six-byte address has been taken.
- R2: The hash is formed as follows:
  - The CRC register starts at 0xFFFFFFFF.
  - Each address byte is shifted in least-significant bit first through the reflected polynomial 0xEDB88320.
  - No final complement is applied.
  - The 32-bit CRC is bit-reversed, and the hash is the upper 8 bits of the reversed value.
- R3: Hash bits [7:5] select table word `hash_table_i[w]`, and hash bits [4:0] select the bit inside that word. A hash of 0xBF addresses bit 31 of word 5 only.
- R4: For a multicast address with pass-all low, `accept_o` equals the selected table bit. `accept_o` is 0 whenever `done_o` is 0.
- R5: With `pass_all_i` high when the sixth byte is taken, every multicast address is accepted, even when the whole table is zero.
- R6: An address is multicast when bit 0 of its first byte is 1. A non-multicast address gives `accept_o`=0 with `done_o`=1, even with pass-all high and an all-ones table.
- R7: `done_o` is high for exactly one cycle, the cycle after the sixth byte is taken, and it is not high earlier in the address.
- R8: A byte with `addr_sof_i`=1 and `addr_valid_i`=1 always becomes byte 0 of a new address. Bytes of an unfinished earlier address have no effect on the result.
- R9: Cycles with `addr_valid_i`=0 are ignored, so gaps between bytes do not change the result. Valid bytes without a start marker after an address completes produce no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_byte_i | input | 8 | Destination-address byte |
| addr_valid_i | input | 1 | Byte on `addr_byte_i` is taken this cycle |
| addr_sof_i | input | 1 | Marks the byte as the first of an address |
| hash_table_i | input | 8x32 | Group table as eight packed 32-bit words, word w = `hash_table_i[w]` |
| pass_all_i | input | 1 | Accept all multicast addresses |
| done_o | output | 1 | One-cycle strobe: decision valid |
| accept_o | output | 1 | Frame accepted (qualified by `done_o`) |

## Verification
Random addresses with random tables compare the decision against a bench model of the reflected CRC and bit reversal. This catches wrong initial values, wrong bit order, a stray final complement or a swapped index split. A directed address that hashes to 0xBF is run against a table holding only word 5 bit 31, and then against a table with every bit set except that one. Together these separate a correct 3/5 word/bit split from any other mapping. Further directed cases cover:
- pass-all with an empty table, and a unicast address with a full table, which exercise the bypass and the multicast test;
- an aborted address followed by a fresh start, and address bytes spread out by idle gaps;
- stray bytes that carry no start marker.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
    parameter int BYTE_W     = 8;
    parameter int ADDR_BYTES = 6;
    parameter int CRC_W      = 32;
    parameter int HASH_W     = 8;
    parameter int NUM_WORDS  = 8;
    parameter int WORD_W     = 32;
    parameter logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    parameter logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

    localparam int SEL_W = $clog2(NUM_WORDS);
    localparam int BIT_W = $clog2(WORD_W);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [HASH_W-1:0] hash_t;

    typedef struct packed {
        logic [SEL_W-1:0] word_sel;
        logic [BIT_W-1:0] bit_sel;
    } tbl_idx_t;

    typedef struct packed {
        logic done;
        logic accept;
    } verdict_t;

    // One byte through the reflected CRC, least-significant bit first.
    function automatic crc_t crc_step_byte(crc_t c_in, logic [BYTE_W-1:0] d);
        crc_t c;
        c = c_in;
        for (int i = 0; i < BYTE_W; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY;
            else             c = c >> 1;
        end
        return c;
    endfunction

    // Upper HASH_W bits of the bit-reversed CRC.
    function automatic hash_t hash_of(crc_t c);
        crc_t r;
        for (int i = 0; i < CRC_W; i++) r[i] = c[CRC_W-1-i];
        return r[CRC_W-1 -: HASH_W];
    endfunction
endpackage

// File: rtl/mhf_crc_accum.sv
module mhf_crc_accum
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              valid_i,
    input  logic              sof_i,
    output logic              last_fire_o,
    output crc_t              crc_next_o,
    output logic              mcast_o
);
    logic [CNT_W-1:0] cnt_q;
    crc_t             crc_q;
    logic             mcast_q;

    logic start_fire, cont_fire;

    assign start_fire  = valid_i && sof_i;
    assign cont_fire   = valid_i && !sof_i && (cnt_q != '0);
    assign last_fire_o = cont_fire && (cnt_q == CNT_W'(ADDR_BYTES - 1));
    assign crc_next_o  = crc_step_byte(start_fire ? CRC_SEED : crc_q, byte_i);
    assign mcast_o     = mcast_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            crc_q   <= CRC_SEED;
            mcast_q <= 1'b0;
        end else if (start_fire) begin
            cnt_q   <= CNT_W'(1);
            crc_q   <= crc_next_o;
            mcast_q <= byte_i[0];
        end else if (last_fire_o) begin
            cnt_q   <= '0;
            crc_q   <= crc_next_o;
        end else if (cont_fire) begin
            cnt_q   <= cnt_q + CNT_W'(1);
            crc_q   <= crc_next_o;
        end
    end

    // R7: byte counter never passes the last in-progress position
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(ADDR_BYTES - 1));

    // R8: a start marker always restarts at byte position 1
    p_sof_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && sof_i) |=> (cnt_q == CNT_W'(1)));

    // R9: idle cycles leave the partial CRC untouched
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(crc_q) && $stable(cnt_q));
endmodule

// File: rtl/mhf_table_select.sv
module mhf_table_select
    import mhf_pkg::*;
(
    input  hash_t                            hash_i,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] table_i,
    output logic                             hit_o
);
    tbl_idx_t             idx;
    logic [NUM_WORDS-1:0] word_hit;

    assign idx = tbl_idx_t'(hash_i);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign word_hit[w] = (idx.word_sel == SEL_W'(w)) && table_i[w][idx.bit_sel];
    end

    assign hit_o = |word_hit;

    // R3: at most one word can claim the lookup
    always_comb begin
        a_one_word_r3: assert ($onehot0(word_hit));
    end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mhf_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [BYTE_W-1:0]                addr_byte_i,
    input  logic                             addr_valid_i,
    input  logic                             addr_sof_i,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] hash_table_i,
    input  logic                             pass_all_i,
    output logic                             done_o,
    output logic                             accept_o
);
    logic     last_fire;
    crc_t     crc_next;
    logic     mcast;
    logic     tbl_hit;
    verdict_t verdict_q;

    mhf_crc_accum u_accum (
        .clk         (clk),
        .rst         (rst),
        .byte_i      (addr_byte_i),
        .valid_i     (addr_valid_i),
        .sof_i       (addr_sof_i),
        .last_fire_o (last_fire),
        .crc_next_o  (crc_next),
        .mcast_o     (mcast)
    );

    mhf_table_select u_select (
        .hash_i  (hash_of(crc_next)),
        .table_i (hash_table_i),
        .hit_o   (tbl_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
        end else begin
            verdict_q.done   <= last_fire;
            verdict_q.accept <= last_fire && mcast && (pass_all_i || tbl_hit);
        end
    end

    assign done_o   = verdict_q.done;
    assign accept_o = verdict_q.accept;

    // R7: the done strobe lasts a single cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4: accept only ever appears with done
    p_accept_qual_r4: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> done_o);

    // R5: pass-all forces acceptance of a multicast address
    p_pass_all_r5: assert property (@(posedge clk) disable iff (rst)
        (last_fire && mcast && pass_all_i) |=> (done_o && accept_o));

    // R6: a unicast address is never accepted
    p_unicast_rej_r6: assert property (@(posedge clk) disable iff (rst)
        (last_fire && !mcast) |=> (done_o && !accept_o));
endmodule

// File: tb/mcast_hash_filter_tb_top.sv
`timescale 1ns/1ps
module mcast_hash_filter_tb_top;
    logic                 clk = 1'b0;
    logic                 rst;
    logic [7:0]           addr_byte_i;
    logic                 addr_valid_i;
    logic                 addr_sof_i;
    logic [7:0][31:0]     hash_table_i;
    logic                 pass_all_i;
    logic                 done_o;
    logic                 accept_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mcast_hash_filter dut_i (
        .clk          (clk),
        .rst          (rst),
        .addr_byte_i  (addr_byte_i),
        .addr_valid_i (addr_valid_i),
        .addr_sof_i   (addr_sof_i),
        .hash_table_i (hash_table_i),
        .pass_all_i   (pass_all_i),
        .done_o       (done_o),
        .accept_o     (accept_o)
    );

    function automatic logic [7:0] model_hash(logic [5:0][7:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        logic [31:0] r;
        for (int b = 0; b < 6; b++)
            for (int i = 0; i < 8; i++)
                c = (c[0] ^ a[b][i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        for (int i = 0; i < 32; i++) r[i] = c[31-i];
        return r[31:24];
    endfunction

    function automatic logic model_accept(logic [5:0][7:0] a, logic [7:0][31:0] t, logic pa);
        logic [7:0] h = model_hash(a);
        if (!a[0][0]) return 1'b0;
        if (pa) return 1'b1;
        return t[h[7:5]][h[4:0]];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one full address; optional idle gaps; checks done timing and decision.
    task automatic run_frame(input logic [5:0][7:0] a, input bit gaps, input string req);
        logic exp = model_accept(a, hash_table_i, pass_all_i);
        for (int b = 0; b < 6; b++) begin
            if (gaps && ($urandom_range(0, 2) == 0)) begin
                @(negedge clk);
                addr_valid_i = 1'b0;
                addr_byte_i  = 8'($urandom);
                addr_sof_i   = 1'($urandom);
            end
            @(negedge clk);
            check(done_o == 1'b0, "R7 early done", done_o, 0);
            addr_valid_i = 1'b1;
            addr_sof_i   = (b == 0);
            addr_byte_i  = a[b];
        end
        @(negedge clk);
        addr_valid_i = 1'b0;
        addr_sof_i   = 1'b0;
        check(done_o == 1'b1, "R7 done after sixth byte", done_o, 1);
        check(accept_o == exp, req, accept_o, exp);
        @(negedge clk);
        check(done_o == 1'b0 && accept_o == 1'b0, "R7 done single cycle", done_o, 0);
    endtask

    logic [5:0][7:0] addr, addr_b;

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; addr_valid_i = 0; addr_sof_i = 0; addr_byte_i = 0;
        hash_table_i = '0; pass_all_i = 0;
        repeat (3) @(negedge clk);
        check(done_o == 0 && accept_o == 0, "R1 reset outputs", {done_o, accept_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(done_o == 0 && accept_o == 0, "R1 idle after reset", {done_o, accept_o}, 0);

        // R3: find a multicast address hashing to 0xBF
        do begin
            for (int b = 0; b < 6; b++) addr[b] = 8'($urandom);
            addr[0][0] = 1'b1;
        end while (model_hash(addr) != 8'hBF);
        hash_table_i = '0;
        hash_table_i[5][31] = 1'b1;
        run_frame(addr, 0, "R3 hash 0xBF hits word5 bit31");
        hash_table_i = '1;
        hash_table_i[5][31] = 1'b0;
        run_frame(addr, 0, "R3 R4 hash 0xBF rejected when bit clear");

        // R5: pass-all with empty table
        hash_table_i = '0;
        pass_all_i = 1'b1;
        run_frame(addr, 0, "R5 pass-all accepts");

        // R6: unicast, full table, pass-all
        hash_table_i = '1;
        addr[0][0] = 1'b0;
        run_frame(addr, 0, "R6 unicast rejected");
        pass_all_i = 1'b0;
        run_frame(addr, 1, "R6 unicast rejected no pass-all");

        // R2: all-ones broadcast address against a single-bit table
        addr = '1;
        hash_table_i = '0;
        hash_table_i[model_hash(addr) >> 5][model_hash(addr) & 8'h1F] = 1'b1;
        run_frame(addr, 0, "R2 broadcast hash");

        // R8: aborted partial address, then a fresh one
        for (int b = 0; b < 6; b++) addr_b[b] = 8'($urandom);
        addr_b[0][0] = 1'b1;
        hash_table_i = '0;
        hash_table_i[model_hash(addr_b) >> 5][model_hash(addr_b) & 8'h1F] = 1'b1;
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            addr_valid_i = 1'b1; addr_sof_i = (b == 0); addr_byte_i = 8'($urandom);
        end
        run_frame(addr_b, 0, "R8 restart discards partial");

        // R9: stray bytes without a start marker
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            check(done_o == 0, "R9 stray bytes no done", done_o, 0);
            addr_valid_i = 1'b1; addr_sof_i = 1'b0; addr_byte_i = 8'($urandom);
        end
        @(negedge clk);
        addr_valid_i = 1'b0;
        check(done_o == 0, "R9 stray bytes no done", done_o, 0);

        // Random mix: R2 R4 R5 R6 R9
        for (int f = 0; f < 60; f++) begin
            for (int w = 0; w < 8; w++) hash_table_i[w] = $urandom;
            for (int b = 0; b < 6; b++) addr[b] = 8'($urandom);
            addr[0][0] = ($urandom_range(0, 3) != 0);
            pass_all_i = ($urandom_range(0, 3) == 0);
            run_frame(addr, 1'($urandom), "R2 R4 random decision");
        end

        finished = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule